// File: doc/BRIEF.md
# Parallel Data Bus Transmit Master

This block drives a synchronous, word-wide parallel data bus from a local word FIFO. On each rising edge of the bus clock it may take one word from the FIFO read port and present it on the bus together with a word-valid strobe. A frame-marker line delimits blocks of words. How that marker is placed depends on the selected framing mode: no framing, a single marked frame, fixed-length repeating frames, or frames whose length is set by an end-of-block tag carried with each FIFO word.

Two flow-control inputs from the receivers throttle the block. The receiver-busy input is asynchronous to the bus clock and passes through a two-flop synchronizer before the block uses it. The hold input is synchronous and stops the word flow on the next edge. In fixed-length mode the block counts transmitted words. When the FIFO's end-of-block tag disagrees with that count, it raises a one-cycle length-error pulse alongside the offending word.

Top module: `pbus_tx_master`

## Requirements
- R1: While rst_ni is low, bus_valid_o, bus_mark_o, bus_err_o and fifo_pop_o are all low. The busy synchronizer resets to the busy state, so no word is sent on the first two edges after reset release.
- R2: A word is sent when, before an edge, the FIFO is not empty, the synchronized busy is low and hold_i is low. In that cycle fifo_pop_o is high. After the edge, bus_data_o carries the word and bus_valid_o is high. On every other edge bus_valid_o goes low. Words leave in FIFO order.
- R3: rx_busy_ai passes through two flops. If it is first seen high at edge k, words may still go at edges k and k+1, and none goes from edge k+2 on. After it is first seen low at edge j, sending resumes at edge j+2.
- R4: hold_i high before an edge blocks the word at that edge. Once hold_i is low again, the very next edge sends a word if one is available.
- R5: mode_i encoding: 0 unframed, 1 single frame, 2 fixed-length repeating, 3 tag-delimited repeating. In mode 0, bus_mark_o never goes high.
- R6: In mode 3, bus_mark_o is high together with bus_valid_o on exactly those words whose FIFO end-of-block tag is set.
- R7: In mode 2, bus_mark_o is high on every frame_len_i-th sent word (frame_len_i ≥ 1). Only sent words are counted, so cycles on which the FIFO is empty do not move the count.
- R8: The fixed-frame word count restarts at zero whenever mode_i changes value.
- R9: In mode 2, bus_err_o is high on exactly those sent words whose end-of-block tag differs from "this word ends the frame". It is low in all other modes.
- R10: In mode 1, after reset, after entry into mode 1, or after an arm_i pulse, the block emits one cycle with bus_mark_o high and bus_valid_o low before the next word. Words after that carry no mark until the next arm_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; all outputs change on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_data_i | input | DATA_W | Word at the FIFO head |
| fifo_last_i | input | 1 | End-of-block tag of the FIFO head word |
| fifo_empty_i | input | 1 | FIFO holds no word |
| fifo_pop_o | output | 1 | Take the head word this cycle |
| mode_i | input | 2 | Framing mode (see R5) |
| frame_len_i | input | LEN_W | Words per frame in fixed-length mode |
| arm_i | input | 1 | Re-arm the single-frame marker |
| rx_busy_ai | input | 1 | Receiver not ready, asynchronous |
| hold_i | input | 1 | Synchronous hold request from receivers |
| bus_data_o | output | DATA_W | Bus data word |
| bus_valid_o | output | 1 | Bus word valid |
| bus_mark_o | output | 1 | Frame marker |
| bus_err_o | output | 1 | Fixed-frame length mismatch on this word |

## Verification
A wrong frame-position count shows up as a marker on the wrong word, and as length-error pulses on correctly tagged words, within one frame of the fault. A synchronizer with the wrong depth or reset value changes how many words cross the busy boundary, which is visible at the edge following the expected stop or restart. A lost or extra arm in single-frame mode appears as a missing or duplicated marker-only cycle ahead of the first word. The bench sweeps frame lengths 1 to 4 with a FIFO that alternates between ready and empty, so count drift caused by idle cycles is exposed.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {
    M_FREE    = 2'd0,
    M_ONESHOT = 2'd1,
    M_FIXED   = 2'd2,
    M_TAGGED  = 2'd3
  } txm_mode_e;
endpackage

// File: rtl/pbus_sync_chain.sv
module pbus_sync_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q <= RST_VAL;
        else         st_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q <= {STAGES{RST_VAL}};
        else         st_q <= {st_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/pbus_frame_pos.sv
module pbus_frame_pos #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             last_o
);
  logic [LEN_W-1:0] cnt_q, pos;

  assign pos    = clr_i ? '0 : cnt_q;
  assign last_o = (pos == len_i - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= last_o ? '0 : pos + LEN_W'(1);
    else            cnt_q <= pos;
endmodule

// File: rtl/pbus_tx_master.sv
module pbus_tx_master
  import pbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] fifo_data_i,
  input  logic              fifo_last_i,
  input  logic              fifo_empty_i,
  output logic              fifo_pop_o,
  input  logic [1:0]        mode_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic              arm_i,
  input  logic              rx_busy_ai,
  input  logic              hold_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_valid_o,
  output logic              bus_mark_o,
  output logic              bus_err_o
);
  txm_mode_e mode, mode_q;
  logic busy_s, can_go, send, emit_mark, mode_chg;
  logic armed_q, armed_eff, frame_last, word_mark;

  assign mode = txm_mode_e'(mode_i);

  pbus_sync_chain #(.STAGES(2), .RST_VAL(1'b1)) u_busy_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_busy_ai),
    .q_o   (busy_s)
  );

  assign mode_chg  = (mode != mode_q);
  assign can_go    = !fifo_empty_i && !busy_s && !hold_i;
  assign armed_eff = armed_q || arm_i || (mode_chg && mode == M_ONESHOT);
  assign emit_mark = (mode == M_ONESHOT) && armed_eff && can_go;
  assign send      = can_go && !emit_mark;
  assign fifo_pop_o = send;

  pbus_frame_pos #(.LEN_W(LEN_W)) u_pos (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (mode_chg),
    .adv_i (send && mode == M_FIXED),
    .len_i (frame_len_i),
    .last_o(frame_last)
  );

  always_comb
    unique case (mode)
      M_TAGGED: word_mark = fifo_last_i;
      M_FIXED:  word_mark = frame_last;
      default:  word_mark = 1'b0;
    endcase

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mode_q      <= M_FREE;
      armed_q     <= 1'b1;
      bus_data_o  <= '0;
      bus_valid_o <= 1'b0;
      bus_mark_o  <= 1'b0;
      bus_err_o   <= 1'b0;
    end else begin
      mode_q      <= mode;
      armed_q     <= emit_mark ? 1'b0 : armed_eff;
      if (send) bus_data_o <= fifo_data_i;
      bus_valid_o <= send;
      bus_mark_o  <= emit_mark || (send && word_mark);
      bus_err_o   <= send && (mode == M_FIXED) && (fifo_last_i != frame_last);
    end

  // R2: a valid word only follows a non-empty FIFO
  a_r2_valid_has_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> !$past(fifo_empty_i));
  // R3: synchronized busy blocks the next edge
  a_r3_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_s |=> !bus_valid_o);
  // R4: hold blocks the next edge
  a_r4_hold_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !bus_valid_o);
  // R5: no marker in unframed mode
  a_r5_free_no_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_mark_o |-> $past(mode_i) != 2'd0);
  // R6: tagged-mode marker rides on a word
  a_r6_tag_mark_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_mark_o && $past(mode_i) == 2'd3) |-> bus_valid_o);
  // R9: length error only on a fixed-mode word
  a_r9_err_on_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> (bus_valid_o && $past(mode_i) == 2'd2));
endmodule

// File: tb/sim_pbus_tx_master.sv
`timescale 1ns/1ps
module sim_pbus_tx_master;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] fifo_data, bus_data;
  logic fifo_last, fifo_empty, fifo_pop, arm, busy, hold;
  logic [1:0] mode;
  logic [7:0] flen;
  logic bus_valid, bus_mark, bus_err;

  pbus_tx_master #(.DATA_W(16), .LEN_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fifo_data_i(fifo_data), .fifo_last_i(fifo_last),
    .fifo_empty_i(fifo_empty), .fifo_pop_o(fifo_pop), .mode_i(mode), .frame_len_i(flen),
    .arm_i(arm), .rx_busy_ai(busy), .hold_i(hold), .bus_data_o(bus_data),
    .bus_valid_o(bus_valid), .bus_mark_o(bus_mark), .bus_err_o(bus_err));

  // bench FIFO
  logic [15:0] mem_d [0:63];
  logic        mem_t [0:63];
  int wr_n = 0, rd_n = 0;
  logic gap = 1'b1;
  assign fifo_empty = (rd_n >= wr_n) || gap;
  assign fifo_data  = mem_d[rd_n[5:0]];
  assign fifo_last  = mem_t[rd_n[5:0]];
  always @(posedge clk) if (fifo_pop) rd_n <= rd_n + 1;

  // bus monitor
  logic [15:0] rx_d [0:255];
  logic rx_m [0:255];
  logic rx_e [0:255];
  int rx_n = 0, lone_n = 0;
  int lone_at [0:15];
  always @(negedge clk) if (rst_n) begin
    if (bus_valid) begin
      rx_d[rx_n[7:0]] = bus_data; rx_m[rx_n[7:0]] = bus_mark; rx_e[rx_n[7:0]] = bus_err;
      rx_n = rx_n + 1;
    end else if (bus_mark) begin
      lone_at[lone_n[3:0]] = rx_n; lone_n = lone_n + 1;
    end
  end

  int n_chk = 0, n_err = 0;
  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask
  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask
  task automatic push(input logic [15:0] d, input logic t);
    mem_d[wr_n[5:0]] = d; mem_t[wr_n[5:0]] = t; wr_n++;
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int base, lbase;
    mode = 2'd0; flen = 8'd1; arm = 0; busy = 0; hold = 0;
    step(3);
    check("R1 valid in reset", int'(bus_valid), 0);
    check("R1 mark in reset", int'(bus_mark), 0);
    check("R1 err in reset", int'(bus_err), 0);
    check("R1 pop in reset", int'(fifo_pop), 0);
    rst_n = 1'b1;
    push(16'h0AA, 1'b0);
    gap = 0;
    step(1); check("R1 no word edge 1", int'(bus_valid), 0);
    step(1); check("R1 no word edge 2", int'(bus_valid), 0);
    step(1); check("R1 word edge 3", int'(bus_valid), 1);
    step(3);

    // unframed: R2, R5
    gap = 1; base = rx_n; lbase = lone_n;
    for (int i = 0; i < 10; i++) push(16'(256 + i), 1'(i % 2));
    gap = 0; step(16);
    check("R2 unframed count", rx_n - base, 10);
    for (int i = 0; i < 10; i++) begin
      check("R2 unframed data", int'(rx_d[base + i]), 256 + i);
      check("R5 unframed no mark", int'(rx_m[base + i]), 0);
    end
    check("R5 no lone mark", lone_n - lbase, 0);

    // tagged: R6, R9
    gap = 1; mode = 2'd3; step(2); base = rx_n;
    for (int i = 0; i < 12; i++) push(16'(768 + i), (i % 4 == 3) || (i == 5));
    gap = 0; step(18);
    check("R6 tagged count", rx_n - base, 12);
    for (int i = 0; i < 12; i++) begin
      check("R6 tagged mark", int'(rx_m[base + i]), int'((i % 4 == 3) || (i == 5)));
      check("R9 no err in tagged", int'(rx_e[base + i]), 0);
    end

    // fixed sweep with FIFO gaps: R7, R9
    for (int L = 1; L <= 4; L++) begin
      gap = 1; mode = 2'd0; step(2);
      flen = 8'(L); base = rx_n;
      for (int i = 0; i < 12; i++) push(16'(512 + L * 16 + i), ((i % L) == L - 1) ^ (i == 5));
      mode = 2'd2; step(1);
      for (int c = 0; c < 40; c++) begin gap = ~gap; step(1); end
      gap = 1; step(2);
      check("R7 fixed count", rx_n - base, 12);
      for (int i = 0; i < 12; i++) begin
        check("R7 fixed data", int'(rx_d[base + i]), 512 + L * 16 + i);
        check("R7 fixed mark", int'(rx_m[base + i]), int'((i % L) == L - 1));
        check("R9 fixed err", int'(rx_e[base + i]), int'(i == 5));
      end
    end

    // count restart on mode change: R8
    gap = 1; mode = 2'd0; step(2); flen = 8'd4; base = rx_n;
    for (int i = 0; i < 6; i++) push(16'(900 + i), i == 5);
    mode = 2'd2; step(1);
    gap = 0; step(2); gap = 1;
    mode = 2'd0; step(2); mode = 2'd2; step(1);
    gap = 0; step(10);
    check("R8 count", rx_n - base, 6);
    for (int i = 0; i < 6; i++) begin
      check("R8 mark after restart", int'(rx_m[base + i]), int'(i == 5));
      check("R8 no err after restart", int'(rx_e[base + i]), 0);
    end

    // single frame: R10
    gap = 1; mode = 2'd0; step(2); base = rx_n; lbase = lone_n;
    for (int i = 0; i < 6; i++) push(16'(1000 + i), 1'b0);
    mode = 2'd1; step(1);
    gap = 0; step(14);
    check("R10 one marker", lone_n - lbase, 1);
    check("R10 marker before data", lone_at[lbase[3:0]] - base, 0);
    check("R10 word count", rx_n - base, 6);
    for (int i = 0; i < 6; i++) check("R10 no mark on word", int'(rx_m[base + i]), 0);
    gap = 1;
    for (int i = 0; i < 3; i++) push(16'(1100 + i), 1'b1);
    arm = 1; step(1); arm = 0;
    gap = 0; step(10);
    check("R10 rearm marker", lone_n - lbase, 2);
    check("R10 rearm position", lone_at[(lbase + 1) % 16] - base, 6);
    for (int i = 6; i < 9; i++) check("R10 rearm no mark", int'(rx_m[base + i]), 0);

    // busy synchronizer: R3
    gap = 1; mode = 2'd0; step(2); base = rx_n;
    for (int i = 0; i < 20; i++) push(16'(1200 + i), 1'b0);
    gap = 0; step(2);
    busy = 1;
    step(1); check("R3 word at k", int'(bus_valid), 1);
    step(1); check("R3 word at k+1", int'(bus_valid), 1);
    step(1); check("R3 stop at k+2", int'(bus_valid), 0);
    step(3); check("R3 still stopped", int'(bus_valid), 0);
    busy = 0;
    step(1); check("R3 none at j", int'(bus_valid), 0);
    step(1); check("R3 none at j+1", int'(bus_valid), 0);
    step(1); check("R3 resume at j+2", int'(bus_valid), 1);
    step(20);
    check("R3 all words", rx_n - base, 20);
    for (int i = 0; i < 20; i++) check("R2 order after busy", int'(rx_d[base + i]), 1200 + i);

    // hold: R4
    gap = 1; step(1);
    for (int i = 0; i < 10; i++) push(16'(1300 + i), 1'b0);
    gap = 0; step(2);
    hold = 1;
    step(1); check("R4 stop next edge", int'(bus_valid), 0);
    step(2); check("R4 held", int'(bus_valid), 0);
    hold = 0;
    step(1); check("R4 restart next edge", int'(bus_valid), 1);
    step(12);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule